// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank with Wake Request

This block is a 32-pin general-purpose I/O bank with a word-wide register port. Each pin is either driven from a data-out register or read as an input. Each input can watch for four kinds of condition: a rising edge, a falling edge, a high level and a low level. Any condition that fires on an input pin is recorded in two separate status words. Each status word has its own enable word and drives its own interrupt line, so two consumers can service the same pins independently.

Status bits are cleared by writing ones to them. Level conditions are checked on every cycle. A level that is still present therefore re-marks its status bit on the cycle after a clear. The same happens after the level enables or the direction register change. Atomic set and clear addresses exist for both enable words, the wake enable word and the data-out word.

A wake-request output follows recorded conditions on pins enabled for wake. It is gated by the system configuration word, which also carries a soft-reset trigger. Two debounce words are plain read/write storage.

Top module: `gpio_wake_bank`

## Requirements
- R1: Register map (byte addresses, 32-bit words):
  - Fixed words: 0x00 revision (reads REV_ID, read-only), 0x14 reads 1, 0x38 synchronized pin inputs (read-only).
  - Configuration: 0x10 system configuration, 0x30 control.
  - Status and enables: 0x18/0x1C status/enable A, 0x28/0x2C status/enable B, 0x20 wake enable.
  - Pins: 0x34 direction, 0x3C data-out.
  - Detector enables: 0x40 level-low, 0x44 level-high, 0x48 rising, 0x4C falling.
  - Debounce storage: 0x50 and 0x54.
  - Aliases: clear/set pairs 0x60/0x64 (enable A), 0x70/0x74 (enable B), 0x80/0x84 (wake enable), 0x90/0x94 (data-out). Reading an alias returns its underlying word.
  - Any other address reads 0.
- R2: `pad_out` equals the data-out word. `pad_drive` is the inverse of the direction word: a direction bit of 1 makes the pin an input and turns its drive off.
- R3: An input pin's sample passes through two flops before the detectors see it. A condition enabled on that pin sets the pin's bit in both status words at the third rising clock edge after the pin changes.
- R4: `irq_a` is high exactly when status A and enable A share a set bit. `irq_b` is the same for the B pair. The two lines are independent.
- R5: Writing a set alias ORs the written word into its target. Writing a clear alias clears the written ones in its target.
- R6: Writing ones to a status word clears those bits. A level condition that still holds sets its bit again on the following edge. Writes to the level or direction words take effect on detection from the next edge.
- R7: A pin whose direction bit is 0 (output) never records a condition.
- R8: `wake_req` is high on the edge after a cycle in which a wake-enabled pin records a condition, but only while configuration bit 2 is 1 and bits 4:3 are not both 0.
- R9: A write to 0x10 stores only bits selected by mask 0x1D. If written bit 1 is 1, the write also performs a soft reset: every bank word returns to its reset value, `wake_req` drops and data-out is kept.
- R10: Control keeps 3 bits. The debounce-enable word at 0x50 keeps 32 bits and the debounce-time word at 0x54 keeps 8 bits. None of them affects pin behaviour.
- R11: After reset, the direction word is all ones, control reads 2, and every other stored word reads 0, including data-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte address of the accessed word |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| pad_in | input | DW | Pin levels from the pads |
| pad_out | output | DW | Pin drive values |
| pad_drive | output | DW | Per-pin drive enable, 1 = driven |
| irq_a | output | 1 | Interrupt line of pair A |
| irq_b | output | 1 | Interrupt line of pair B |
| wake_req | output | 1 | Wake request |

## Verification
The bench builds the bank at the default 32-bit width with `REV_ID` overridden to 0xA5. The overridden value lets the revision read prove that the parameter reaches the read path rather than a literal. With the full 32 bits, pins 0 to 15 can be set as outputs while pins 16 and up act as inputs. Edge, level, wake and output-pin cases can then all run on separate pins of one configuration. A behavioural model that tracks pin history in a queue predicts every output on every cycle.

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [DW-1:0] REV_ID = 'h31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_drive,
  output logic          irq_a,
  output logic          irq_b,
  output logic          wake_req
);
  localparam logic [AW-1:0] A_REV = AW'('h00), A_CFG = AW'('h10), A_SYS = AW'('h14),
    A_STA = AW'('h18), A_ENA = AW'('h1C), A_WKE = AW'('h20), A_STB = AW'('h28),
    A_ENB = AW'('h2C), A_CTL = AW'('h30), A_DIR = AW'('h34), A_DIN = AW'('h38),
    A_DOUT = AW'('h3C), A_LLO = AW'('h40), A_LHI = AW'('h44), A_RIS = AW'('h48),
    A_FAL = AW'('h4C), A_DBE = AW'('h50), A_DBT = AW'('h54),
    A_ENA_C = AW'('h60), A_ENA_S = AW'('h64), A_ENB_C = AW'('h70), A_ENB_S = AW'('h74),
    A_WKE_C = AW'('h80), A_WKE_S = AW'('h84), A_DOUT_C = AW'('h90), A_DOUT_S = AW'('h94);
  localparam logic [4:0] CFG_KEEP = 5'h1D;

  logic [DW-1:0] smp1, smp2, smp3;
  logic [DW-1:0] st_a, st_b, en_a, en_b, wk_en, dir_in, dout;
  logic [DW-1:0] lvl_lo, lvl_hi, rise_en, fall_en, db_en;
  logic [7:0]    db_time;
  logic [4:0]    cfg;
  logic [2:0]    ctl;
  logic          wake_q;
  logic [DW-1:0] hit, clr_a, clr_b;
  logic          soft_rst, wake_ok;

  assign hit = dir_in & ((smp2 & ~smp3 & rise_en) | (~smp2 & smp3 & fall_en) |
                         (smp2 & lvl_hi) | (~smp2 & lvl_lo));
  assign clr_a    = (bus_we && bus_addr == A_STA) ? bus_wdata : '0;
  assign clr_b    = (bus_we && bus_addr == A_STB) ? bus_wdata : '0;
  assign soft_rst = bus_we && bus_addr == A_CFG && bus_wdata[1];
  assign wake_ok  = cfg[2] && (cfg[4:3] != 2'b00);

  assign pad_out   = dout;
  assign pad_drive = ~dir_in;
  assign irq_a     = |(st_a & en_a);
  assign irq_b     = |(st_b & en_b);
  assign wake_req  = wake_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp1 <= '0; smp2 <= '0; smp3 <= '0;
    end else begin
      smp1 <= pad_in; smp2 <= smp1; smp3 <= smp2;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; ctl <= 3'd2; st_a <= '0; st_b <= '0; en_a <= '0; en_b <= '0;
      wk_en <= '0; dir_in <= '1; dout <= '0; lvl_lo <= '0; lvl_hi <= '0;
      rise_en <= '0; fall_en <= '0; db_en <= '0; db_time <= '0; wake_q <= 1'b0;
    end else if (soft_rst) begin
      cfg <= bus_wdata[4:0] & CFG_KEEP; ctl <= 3'd2; st_a <= '0; st_b <= '0;
      en_a <= '0; en_b <= '0; wk_en <= '0; dir_in <= '1; lvl_lo <= '0; lvl_hi <= '0;
      rise_en <= '0; fall_en <= '0; db_en <= '0; db_time <= '0; wake_q <= 1'b0;
    end else begin
      st_a   <= (st_a & ~clr_a) | hit;
      st_b   <= (st_b & ~clr_b) | hit;
      wake_q <= wake_ok && |(hit & wk_en);
      if (bus_we)
        case (bus_addr)
          A_CFG:    cfg     <= bus_wdata[4:0] & CFG_KEEP;
          A_CTL:    ctl     <= bus_wdata[2:0];
          A_ENA:    en_a    <= bus_wdata;
          A_ENA_C:  en_a    <= en_a & ~bus_wdata;
          A_ENA_S:  en_a    <= en_a | bus_wdata;
          A_ENB:    en_b    <= bus_wdata;
          A_ENB_C:  en_b    <= en_b & ~bus_wdata;
          A_ENB_S:  en_b    <= en_b | bus_wdata;
          A_WKE:    wk_en   <= bus_wdata;
          A_WKE_C:  wk_en   <= wk_en & ~bus_wdata;
          A_WKE_S:  wk_en   <= wk_en | bus_wdata;
          A_DIR:    dir_in  <= bus_wdata;
          A_DOUT:   dout    <= bus_wdata;
          A_DOUT_C: dout    <= dout & ~bus_wdata;
          A_DOUT_S: dout    <= dout | bus_wdata;
          A_LLO:    lvl_lo  <= bus_wdata;
          A_LHI:    lvl_hi  <= bus_wdata;
          A_RIS:    rise_en <= bus_wdata;
          A_FAL:    fall_en <= bus_wdata;
          A_DBE:    db_en   <= bus_wdata;
          A_DBT:    db_time <= bus_wdata[7:0];
          default: ;
        endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:                    bus_rdata = REV_ID;
      A_CFG:                    bus_rdata = DW'(cfg);
      A_SYS:                    bus_rdata = DW'(1);
      A_STA:                    bus_rdata = st_a;
      A_ENA, A_ENA_C, A_ENA_S:  bus_rdata = en_a;
      A_WKE, A_WKE_C, A_WKE_S:  bus_rdata = wk_en;
      A_STB:                    bus_rdata = st_b;
      A_ENB, A_ENB_C, A_ENB_S:  bus_rdata = en_b;
      A_CTL:                    bus_rdata = DW'(ctl);
      A_DIR:                    bus_rdata = dir_in;
      A_DIN:                    bus_rdata = smp2;
      A_DOUT, A_DOUT_C, A_DOUT_S: bus_rdata = dout;
      A_LLO:                    bus_rdata = lvl_lo;
      A_LHI:                    bus_rdata = lvl_hi;
      A_RIS:                    bus_rdata = rise_en;
      A_FAL:                    bus_rdata = fall_en;
      A_DBE:                    bus_rdata = db_en;
      A_DBT:                    bus_rdata = DW'(db_time);
      default:                  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_wake_bank_chk.sv
module gpio_wake_bank_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] pad_out,
  input logic [DW-1:0] pad_drive,
  input logic          irq_a,
  input logic          irq_b,
  input logic          wake_req,
  input logic [4:0]    cfg
);
  // R4
  enable_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h1C) && bus_wdata == '0) |=> !irq_a);
  // R2
  dir_write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h34)) |=> pad_drive == ~$past(bus_wdata));
  // R5
  dout_set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h94)) |=> (pad_out & $past(bus_wdata)) == $past(bus_wdata));
  // R9
  soft_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h10) && bus_wdata[1])
      |=> (!irq_a && !irq_b && !wake_req && pad_drive == '0 && $stable(pad_out)));
  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[2] || cfg[4:3] == 2'b00) |=> !wake_req);
endmodule

bind gpio_wake_bank gpio_wake_bank_chk #(.DW(DW), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_out(pad_out), .pad_drive(pad_drive), .irq_a(irq_a), .irq_b(irq_b),
  .wake_req(wake_req), .cfg(cfg)
);

// File: tb/gpio_wake_bank_test.sv
module gpio_wake_bank_test;
  localparam logic [31:0] REV = 32'hA5;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, pad_in = 0, bus_rdata, pad_out, pad_drive;
  logic irq_a, irq_b, wake_req;
  int checks = 0, fails = 0;
  bit finished = 0;

  gpio_wake_bank #(.REV_ID(REV)) uut (.*);

  always #2 clk = ~clk;

  logic [31:0] m_sta, m_stb, m_ena, m_enb, m_wke, m_dir, m_dout, m_llo, m_lhi;
  logic [31:0] m_ris, m_fal, m_dbe;
  logic [7:0] m_dbt;
  logic [4:0] m_cfg;
  logic [2:0] m_ctl;
  logic m_wake;
  logic [31:0] hist[$];

  task automatic m_reset(bit keep_out);
    m_sta = 0; m_stb = 0; m_ena = 0; m_enb = 0; m_wke = 0; m_dir = '1;
    m_llo = 0; m_lhi = 0; m_ris = 0; m_fal = 0; m_dbe = 0; m_dbt = 0;
    m_ctl = 2; m_cfg = 0; m_wake = 0;
    if (!keep_out) m_dout = 0;
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return REV;
      8'h10: return {27'd0, m_cfg};
      8'h14: return 1;
      8'h18: return m_sta;
      8'h1C, 8'h60, 8'h64: return m_ena;
      8'h20, 8'h80, 8'h84: return m_wke;
      8'h28: return m_stb;
      8'h2C, 8'h70, 8'h74: return m_enb;
      8'h30: return {29'd0, m_ctl};
      8'h34: return m_dir;
      8'h38: return hist[1];
      8'h3C, 8'h90, 8'h94: return m_dout;
      8'h40: return m_llo;
      8'h44: return m_lhi;
      8'h48: return m_ris;
      8'h4C: return m_fal;
      8'h50: return m_dbe;
      8'h54: return {24'd0, m_dbt};
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset(0);
      hist = '{0, 0, 0};
    end else begin
      logic [31:0] cur, old, ev, w;
      cur = hist[1]; old = hist[2]; w = bus_wdata;
      ev = 0;
      for (int i = 0; i < 32; i++)
        if (m_dir[i]) begin
          if (cur[i] && !old[i] && m_ris[i]) ev[i] = 1;
          if (!cur[i] && old[i] && m_fal[i]) ev[i] = 1;
          if (cur[i] && m_lhi[i]) ev[i] = 1;
          if (!cur[i] && m_llo[i]) ev[i] = 1;
        end
      if (bus_we && bus_addr == 8'h10 && w[1]) begin
        m_reset(1);
        m_cfg = w[4:0] & 5'h1D;
      end else begin
        m_wake = (m_cfg[2] && m_cfg[4:3] != 0 && (ev & m_wke) != 0);
        if (bus_we && bus_addr == 8'h18) m_sta = m_sta & ~w;
        if (bus_we && bus_addr == 8'h28) m_stb = m_stb & ~w;
        m_sta |= ev; m_stb |= ev;
        if (bus_we)
          case (bus_addr)
            8'h10: m_cfg = w[4:0] & 5'h1D;
            8'h30: m_ctl = w[2:0];
            8'h1C: m_ena = w;  8'h60: m_ena &= ~w; 8'h64: m_ena |= w;
            8'h2C: m_enb = w;  8'h70: m_enb &= ~w; 8'h74: m_enb |= w;
            8'h20: m_wke = w;  8'h80: m_wke &= ~w; 8'h84: m_wke |= w;
            8'h3C: m_dout = w; 8'h90: m_dout &= ~w; 8'h94: m_dout |= w;
            8'h34: m_dir = w;
            8'h40: m_llo = w; 8'h44: m_lhi = w; 8'h48: m_ris = w; 8'h4C: m_fal = w;
            8'h50: m_dbe = w; 8'h54: m_dbt = w[7:0];
            default: ;
          endcase
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
    #1;
    if (rst_n) begin
      cmp("R1 model rdata", bus_rdata, m_read(bus_addr));
      cmp("R4 model irq_a", {31'd0, irq_a}, {31'd0, (m_sta & m_ena) != 0});
      cmp("R4 model irq_b", {31'd0, irq_b}, {31'd0, (m_stb & m_enb) != 0});
      cmp("R2 model pad_out", pad_out, m_dout);
      cmp("R2 model pad_drive", pad_drive, ~m_dir);
      cmp("R8 model wake_req", {31'd0, wake_req}, {31'd0, m_wake});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] m, logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    cmp(tag, bus_rdata & m, exp & m);
  endtask

  task automatic pin(int i, logic v);
    @(negedge clk); pad_in[i] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic wake_seen(string tag, int i, bit exp);
    bit seen = 0;
    @(negedge clk); pad_in[i] = 1;
    for (int k = 0; k < 6; k++) begin @(negedge clk); seen |= wake_req; end
    cmp(tag, {31'd0, seen}, {31'd0, exp});
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=running expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 R1 reset state and fixed words
    rd("R1 revision", 8'h00, '1, REV);
    rd("R1 fixed status", 8'h14, '1, 1);
    rd("R11 direction", 8'h34, '1, '1);
    rd("R11 control", 8'h30, '1, 2);
    rd("R11 data-out", 8'h3C, '1, 0);
    rd("R11 status A", 8'h18, '1, 0);
    rd("R1 unmapped", 8'h24, '1, 0);
    wr(8'h00, 32'h1234);
    rd("R1 revision read-only", 8'h00, '1, REV);
    // R2 R5 outputs and aliases
    wr(8'h34, 32'hFFFF_0000);
    wr(8'h3C, 32'h0000_00F0);
    wr(8'h94, 32'h1);
    wr(8'h90, 32'h10);
    rd("R5 data-out alias", 8'h94, '1, 32'hE1);
    cmp("R2 pad_out", pad_out, 32'hE1);
    cmp("R2 pad_drive", pad_drive, 32'h0000_FFFF);
    // R3 R4 rising edge on pin 16
    wr(8'h48, 32'h0001_0000);
    wr(8'h64, 32'h0001_0000);
    pin(16, 1);
    rd("R3 rise status A", 8'h18, '1, 32'h0001_0000);
    rd("R3 rise status B", 8'h28, '1, 32'h0001_0000);
    cmp("R4 irq_a set", {31'd0, irq_a}, 1);
    cmp("R4 irq_b quiet", {31'd0, irq_b}, 0);
    wr(8'h60, 32'h0001_0000);
    cmp("R5 clear alias drops irq_a", {31'd0, irq_a}, 0);
    wr(8'h74, 32'h0001_0000);
    cmp("R4 irq_b via enable B", {31'd0, irq_b}, 1);
    wr(8'h18, '1);
    rd("R6 W1C status A", 8'h18, '1, 0);
    rd("R6 status B untouched", 8'h28, '1, 32'h0001_0000);
    wr(8'h28, '1);
    // R3 falling on pin 17
    wr(8'h4C, 32'h0002_0000);
    pin(17, 1);
    rd("R3 no fall on rise", 8'h18, 32'h0002_0000, 0);
    pin(17, 0);
    rd("R3 fall status", 8'h18, 32'h0002_0000, 32'h0002_0000);
    wr(8'h18, '1);
    // R6 level high re-marks after clear
    wr(8'h44, 32'h0004_0000);
    pin(18, 1);
    wr(8'h18, 32'h0004_0000);
    rd("R6 level re-marks", 8'h18, 32'h0004_0000, 32'h0004_0000);
    pin(18, 0);
    wr(8'h18, 32'h0004_0000);
    rd("R6 level gone stays clear", 8'h18, 32'h0004_0000, 0);
    // R7 output pin ignored, then R6 direction re-evaluation
    wr(8'h48, 32'h0001_0001);
    wr(8'h44, 32'h0000_0001);
    pin(0, 1);
    rd("R7 output pin no status", 8'h18, 32'h1, 0);
    wr(8'h34, 32'hFFFF_0001);
    rd("R6 direction write level", 8'h18, 32'h1, 32'h1);
    wr(8'h44, 0);
    wr(8'h18, '1);
    // R8 wake gating
    wr(8'h10, 32'h0C);
    wr(8'h84, 32'h0028_0000);
    wr(8'h48, 32'h0028_0000);
    wake_seen("R8 wake raised", 19, 1);
    wr(8'h10, 32'h04);
    wake_seen("R8 wake gated by idle bits", 21, 0);
    rd("R8 status still set", 8'h18, 32'h0020_0000, 32'h0020_0000);
    // R10 storage words
    wr(8'h50, 32'hDEAD_BEEF);
    wr(8'h54, 32'h1FF);
    wr(8'h30, 32'hF);
    rd("R10 debounce enable", 8'h50, '1, 32'hDEAD_BEEF);
    rd("R10 debounce time", 8'h54, '1, 32'hFF);
    rd("R10 control", 8'h30, '1, 7);
    // R9 config mask and soft reset
    wr(8'h10, 32'hFD);
    rd("R9 config mask", 8'h10, '1, 32'h1D);
    wr(8'h64, 32'h3);
    wr(8'h10, 32'hFF);
    rd("R9 config after reset", 8'h10, '1, 32'h1D);
    rd("R9 enable A cleared", 8'h1C, '1, 0);
    rd("R9 direction restored", 8'h34, '1, '1);
    rd("R9 control restored", 8'h30, '1, 2);
    rd("R9 debounce cleared", 8'h50, '1, 0);
    rd("R9 data-out kept", 8'h3C, '1, 32'hE1);
    pad_in = 0;
    repeat (5) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule